// File: doc/BRIEF.md
# Long Multiply-Accumulate Unit

This block is a fixed-latency integer multiplier for a processor's execute stage. It takes two 32-bit operands and, for the accumulating forms, an existing accumulator given as a 32-bit high word and a 32-bit low word. Depending on a 4-bit operation select, it returns either a 32-bit result in the low result word or a 64-bit result split across the high and low result words. It also keeps the four condition flags: negative, zero, carry and overflow.

A single multiplier array serves both the unsigned and the signed 64-bit forms. The signed form sign-extends both operands to 64 bits before the array, and the unsigned form zero-extends them. One adder after the array folds in the accumulator. The issuing logic raises `start` for one cycle. The unit captures every input on that edge and raises `done` for one cycle a fixed number of cycles later. While the unit is busy it ignores every input. An undefined select code raises `illegal` for one cycle and changes nothing.

Top module: `mul_acc_unit`

## Requirements
- R1: Select 0x0 writes bits 31:0 of the product of `src_a` and `src_b` to `res_lo`. `res_hi` keeps its previous value.
- R2: Select 0x1 writes bits 31:0 of (`src_a` times `src_b` plus `acc_lo`) to `res_lo`. `res_hi` keeps its previous value and `acc_hi` has no effect.
- R3: Select 0x4 forms the unsigned 64-bit product. Bits 31:0 go to `res_lo` and bits 63:32 go to `res_hi`.
- R4: Select 0x6 forms the 64-bit product of the two operands read as two's-complement values, and splits it the same way as R3.
- R5: Select 0x7 adds {`acc_hi`,`acc_lo`} to the unsigned 64-bit product, wrapping modulo 2^64, and splits the sum the same way as R3.
- R6: When `set_flags` was high at start, `flag_n` takes bit 31 of a 32-bit result or bit 63 of a 64-bit result. `flag_z` is set when the whole result is zero. When `set_flags` was low, N and Z keep their values.
- R7: The 32-bit forms (0x0, 0x1) never change `flag_c` or `flag_v`. A 64-bit form started with `set_flags` high sets both flags to 1.
- R8: Select codes 0x2, 0x3, 0x5 and 0x8 to 0xF are illegal. They pulse `illegal` for one cycle, in the cycle after start, and leave `busy`, `done`, the results and the flags unchanged.
- R9: For a legal start, `busy` is high from the cycle after start until the results appear. `done` is high for exactly one cycle, LATENCY cycles after the start edge, and the results and flags are valid from that cycle.
- R10: While `busy` is high, `start` and every operand input are ignored. Operands that change after the start edge do not affect the result.
- R11: After reset, `busy`, `done`, `illegal`, `res_lo`, `res_hi` and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; sampled only while idle |
| op_sel | input | 4 | Operation select code |
| set_flags | input | 1 | Update the condition flags with this result |
| src_a | input | 32 | First multiplicand |
| src_b | input | 32 | Second multiplicand |
| acc_hi | input | 32 | Accumulator high word |
| acc_lo | input | 32 | Accumulator low word |
| busy | output | 1 | An operation is in flight |
| done | output | 1 | One-cycle pulse: results valid |
| illegal | output | 1 | One-cycle pulse: undefined select rejected |
| res_lo | output | 32 | Result low word |
| res_hi | output | 32 | Result high word |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The assertions watch the cycle-level rules on every cycle. `done` is a single-cycle pulse and `busy` only drops with it. `illegal` never coincides with `busy` or `done`. The results and flags stay put outside the `done` cycle. Carry and overflow hold across 32-bit forms, and N and Z hold when flag update is off. The arithmetic itself can only be shown by the bench's scenarios: the signed and unsigned splits, the accumulate wrap, and the zero and negative flag cases. The same goes for the exact completion cycle and for operand changes and extra starts issued mid-operation being ignored.

// File: rtl/mul_acc_unit.sv
module mul_acc_unit #(
  parameter int WIDTH   = 32,
  parameter int LATENCY = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       op_sel,
  input  logic             set_flags,
  input  logic [WIDTH-1:0] src_a,
  input  logic [WIDTH-1:0] src_b,
  input  logic [WIDTH-1:0] acc_hi,
  input  logic [WIDTH-1:0] acc_lo,
  output logic             busy,
  output logic             done,
  output logic             illegal,
  output logic [WIDTH-1:0] res_lo,
  output logic [WIDTH-1:0] res_hi,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v
);
  localparam int DW = 2 * WIDTH;
  localparam int CW = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam logic [3:0] OP_MUL32  = 4'h0;
  localparam logic [3:0] OP_MAC32  = 4'h1;
  localparam logic [3:0] OP_UMUL64 = 4'h4;
  localparam logic [3:0] OP_SMUL64 = 4'h6;
  localparam logic [3:0] OP_UMAC64 = 4'h7;

  logic [3:0]       op_q;
  logic             sf_q;
  logic [WIDTH-1:0] a_q, b_q, hi_q, lo_q;
  logic [CW-1:0]    cnt;

  logic legal;
  assign legal = (op_sel == OP_MUL32) || (op_sel == OP_MAC32) || (op_sel == OP_UMUL64) ||
                 (op_sel == OP_SMUL64) || (op_sel == OP_UMAC64);

  logic long_q, sgn;
  assign long_q = (op_q == OP_UMUL64) || (op_q == OP_SMUL64) || (op_q == OP_UMAC64);
  assign sgn    = (op_q == OP_SMUL64);

  logic [DW-1:0] ext_a, ext_b, prod, acc, sum;
  assign ext_a = {{WIDTH{sgn & a_q[WIDTH-1]}}, a_q};
  assign ext_b = {{WIDTH{sgn & b_q[WIDTH-1]}}, b_q};
  assign prod  = ext_a * ext_b;
  assign acc   = (op_q == OP_UMAC64) ? {hi_q, lo_q} :
                 (op_q == OP_MAC32)  ? {{WIDTH{1'b0}}, lo_q} : '0;
  assign sum   = prod + acc;

  logic nxt_n, nxt_z;
  assign nxt_n = long_q ? sum[DW-1] : sum[WIDTH-1];
  assign nxt_z = long_q ? (sum == '0) : (sum[WIDTH-1:0] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; illegal <= 1'b0;
      res_lo <= '0; res_hi <= '0;
      flag_n <= 1'b0; flag_z <= 1'b0; flag_c <= 1'b0; flag_v <= 1'b0;
      op_q <= '0; sf_q <= 1'b0; cnt <= '0;
      a_q <= '0; b_q <= '0; hi_q <= '0; lo_q <= '0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      if (busy) begin
        if (cnt == '0) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          res_lo <= sum[WIDTH-1:0];
          if (long_q) res_hi <= sum[DW-1:WIDTH];
          if (sf_q) begin
            flag_n <= nxt_n;
            flag_z <= nxt_z;
            if (long_q) begin
              flag_c <= 1'b1;
              flag_v <= 1'b1;
            end
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (start) begin
        if (legal) begin
          busy <= 1'b1;
          cnt  <= CW'(LATENCY - 1);
          op_q <= op_sel; sf_q <= set_flags;
          a_q  <= src_a;  b_q  <= src_b;
          hi_q <= acc_hi; lo_q <= acc_lo;
        end else begin
          illegal <= 1'b1;
        end
      end
    end
  end

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_busy_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r8_illegal_alone: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!done && !busy));
  a_r10_results_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_lo) && $stable(res_hi) && $stable(flag_n) && $stable(flag_z)
               && $stable(flag_c) && $stable(flag_v)));
  a_r7_cv_hold_short: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !long_q) |-> ($stable(flag_c) && $stable(flag_v)));
  a_r6_nz_hold_noflags: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !sf_q) |-> ($stable(flag_n) && $stable(flag_z)));
endmodule

// File: tb/mul_acc_unit_test.sv
module mul_acc_unit_test;
  localparam int LAT = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, set_flags = 1'b0;
  logic [3:0] op_sel = '0;
  logic [31:0] src_a = '0, src_b = '0, acc_hi = '0, acc_lo = '0;
  logic busy, done, illegal, flag_n, flag_z, flag_c, flag_v;
  logic [31:0] res_lo, res_hi;

  mul_acc_unit #(.WIDTH(32), .LATENCY(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .set_flags(set_flags),
    .src_a(src_a), .src_b(src_b), .acc_hi(acc_hi), .acc_lo(acc_lo),
    .busy(busy), .done(done), .illegal(illegal), .res_lo(res_lo), .res_hi(res_hi),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v));

  always #5 clk = ~clk;

  typedef struct {
    bit          ill;
    int unsigned when;
    bit [31:0]   lo, hi;
    bit          n, z, c, v;
    string       tag;
  } exp_t;

  exp_t q[$];
  int unsigned cyc = 0;
  int checks = 0, fails = 0;
  bit [31:0] m_lo = 0, m_hi = 0;
  bit m_n = 0, m_z = 0, m_c = 0, m_v = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R9 watchdog: act=hung exp=finished");
    report();
  end

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (rst_n && (done || illegal)) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R10 unexpected completion: act done=%0b illegal=%0b exp none", done, illegal);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.ill != illegal || e.when != cyc) begin
          fails++;
          $display("FAIL %s kind/time: act ill=%0b cyc=%0d exp ill=%0b cyc=%0d",
                   e.tag, illegal, cyc, e.ill, e.when);
        end
        checks++;
        if (res_lo !== e.lo || res_hi !== e.hi ||
            {flag_n, flag_z, flag_c, flag_v} !== {e.n, e.z, e.c, e.v}) begin
          fails++;
          $display("FAIL %s data: act hi=%h lo=%h nzcv=%b%b%b%b exp hi=%h lo=%h nzcv=%b%b%b%b",
                   e.tag, res_hi, res_lo, flag_n, flag_z, flag_c, flag_v,
                   e.hi, e.lo, e.n, e.z, e.c, e.v);
        end
      end
    end
  end

  // reference model: derives the expected outcome from the requirements
  task automatic push(input bit [3:0] op, input bit sf, input bit [31:0] a, b, hi, lo,
                      input string tag);
    exp_t e;
    longint unsigned p;
    longint sa, sb;
    bit is_long;
    bit [31:0] r32;
    e.tag = tag;
    e.ill = 0;
    is_long = 0;
    r32 = 0;
    p = 0;
    case (op)
      4'h0: r32 = a * b;
      4'h1: r32 = a * b + lo;
      4'h4: begin p = longint'(a) * longint'(b); is_long = 1; end
      4'h6: begin sa = $signed(a); sb = $signed(b); p = sa * sb; is_long = 1; end
      4'h7: begin p = longint'(a) * longint'(b) + {hi, lo}; is_long = 1; end
      default: e.ill = 1;
    endcase
    if (!e.ill) begin
      if (is_long) begin
        m_lo = p[31:0]; m_hi = p[63:32];
        if (sf) begin m_n = p[63]; m_z = (p == 0); m_c = 1; m_v = 1; end
      end else begin
        m_lo = r32;
        if (sf) begin m_n = r32[31]; m_z = (r32 == 0); end
      end
    end
    e.when = cyc + 1 + (e.ill ? 0 : LAT);
    e.lo = m_lo; e.hi = m_hi;
    e.n = m_n; e.z = m_z; e.c = m_c; e.v = m_v;
    q.push_back(e);
  endtask

  task automatic run_op(input bit [3:0] op, input bit sf, input bit [31:0] a, b, hi, lo,
                        input string tag, input bit poke);
    @(negedge clk);
    op_sel = op; set_flags = sf; src_a = a; src_b = b; acc_hi = hi; acc_lo = lo;
    start = 1'b1;
    push(op, sf, a, b, hi, lo, tag);
    @(negedge clk);
    start = 1'b0;
    src_a = ~a; src_b = b ^ 32'h5a5a_0001; acc_hi = ~hi; acc_lo = lo + 32'd77;
    op_sel = 4'h7; set_flags = ~sf;
    checks++;
    if (busy !== (q[$].ill ? 1'b0 : 1'b1)) begin
      fails++;
      $display("FAIL R9 busy after start (%s): act=%0b exp=%0b", tag, busy, !q[$].ill);
    end
    if (poke) begin
      start = 1'b1; op_sel = 4'h0; src_a = 32'd9; src_b = 32'd9;  // R10: must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    repeat (LAT + 1) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R11 reset state
    if ({busy, done, illegal, res_lo, res_hi, flag_n, flag_z, flag_c, flag_v} !== '0) begin
      fails++;
      $display("FAIL R11 reset: act busy=%0b lo=%h hi=%h nzcv=%b%b%b%b exp all zero",
               busy, res_lo, res_hi, flag_n, flag_z, flag_c, flag_v);
    end
    rst_n = 1'b1;
    @(negedge clk);

    run_op(4'h0, 1, 32'd3, 32'd5, 32'h0, 32'h0, "R1 mul small", 0);
    run_op(4'h0, 1, 32'h0001_0000, 32'h0001_0000, 32'h0, 32'h0, "R6 mul zero flag", 0);
    run_op(4'h1, 1, 32'd7, 32'd6, 32'hdead_beef, 32'd100, "R2 mac32", 0);
    run_op(4'h4, 1, 32'hffff_ffff, 32'hffff_ffff, 32'h0, 32'h0, "R3 umul64 max R7", 0);
    run_op(4'h0, 0, 32'h8000_0001, 32'd1, 32'h0, 32'h0, "R6 no-flag hold R7", 0);
    run_op(4'h0, 1, 32'h8000_0000, 32'd1, 32'h0, 32'h0, "R7 cv hold neg", 0);
    run_op(4'h6, 1, 32'hffff_fffe, 32'd3, 32'h0, 32'h0, "R4 smul64 neg", 0);
    run_op(4'h6, 0, 32'h8000_0000, 32'h8000_0000, 32'h0, 32'h0, "R4 smul64 minmin", 0);
    run_op(4'h7, 1, 32'hffff_ffff, 32'hffff_ffff, 32'hffff_ffff, 32'hffff_ffff, "R5 umac64 wrap", 0);
    run_op(4'h7, 1, 32'h0, 32'h1234, 32'h0, 32'h0, "R5 umac64 zero", 0);
    run_op(4'h2, 1, 32'd4, 32'd4, 32'h0, 32'h0, "R8 illegal 2", 0);
    run_op(4'h3, 1, 32'd4, 32'd4, 32'h0, 32'h0, "R8 illegal 3", 0);
    run_op(4'h5, 1, 32'd4, 32'd4, 32'h0, 32'h0, "R8 illegal 5", 0);
    run_op(4'hb, 1, 32'd4, 32'd4, 32'h0, 32'h0, "R8 illegal b", 0);
    run_op(4'h4, 1, 32'h1234_5678, 32'h9abc_def0, 32'h0, 32'h0, "R10 poke during busy", 1);
    run_op(4'h1, 0, 32'h0000_0010, 32'h0000_0020, 32'h0, 32'hffff_ffff, "R10 poke mac32", 1);
    for (int i = 0; i < 24; i++) begin
      bit [3:0] ops[5] = '{4'h0, 4'h1, 4'h4, 4'h6, 4'h7};
      run_op(ops[i % 5], (i % 3) != 0, $urandom, $urandom, $urandom, $urandom, "R9 mixed", i % 4 == 0);
    end
    repeat (4) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R9 missing completions: act pending=%0d exp 0", q.size());
    end
    report();
  end
endmodule